// File: doc/BRIEF.md
# Interrupt Controller Command Sequencer

This block sits on the control side of one bank of an interrupt controller. Software configures the bank through single-byte writes to two ports: a command port and a data port. A short initialization script of two to four words runs first. The first word, sent on the command port, restarts the script. The words after it go to the data port, and flags in the first word decide which of the later words are expected. One of those words is the vector base that the bank reports for its lines.

Once the script has finished, a data-port write replaces the interrupt mask. A command-port write is then taken as an operation word. An end-of-interrupt word asks the priority logic to clear one in-service bit. That bit is either the one named in the word, or the lowest-numbered bit set in the in-service vector that the priority logic presents. A second operation format is accepted and has no effect. Writes that are malformed, or that come at the wrong moment, raise a one-cycle error pulse. Every well-formed write also raises a one-cycle pulse that tells the CPU side to drop any interrupt it has marked as pending.

All outputs are registered. A write seen at a rising clock edge is reflected in the outputs from that same edge onward, and each pulse lasts exactly one cycle.

Top module: `icu_cmd_seq`

## Requirements
- R1: After reset the sequencer is idle, `seq_ready` is 0, `vec_base` is 0x00, `irq_mask` is 0xFF, and `isr_clr`, `clr_pend` and `cmd_err` are 0.
- R2: A command-port write (`wr_sel`=0) with bit 4 set is an initialization start word in every state. It drops `seq_ready` and makes the sequencer expect the vector-base word. Its bit 1 is the single-bank flag and its bit 0 is the fourth-word flag.
- R3: The first data-port write after the start word loads `vec_base`. The next word expected is the cascade word if the single-bank flag was 0, otherwise the mode word if the fourth-word flag was 1, otherwise none, in which case `seq_ready` becomes 1. Words taken during initialization leave `irq_mask` unchanged.
- R4: After the cascade word the sequencer expects the mode word if the fourth-word flag was 1, and becomes ready otherwise. After the mode word it always becomes ready.
- R5: A data-port write while idle (before any start word) or while ready loads `irq_mask` with the written byte.
- R6: While ready, a command word with bits 4:3 = 00, bit 5 = 1 (end of interrupt), bit 7 = 0 and bit 6 = 1 (specific) drives `isr_clr` to the one-hot code of bits 2:0 for one cycle.
- R7: The same word with bit 6 = 0 drives `isr_clr` to the lowest-numbered set bit of `isr_in` for one cycle, or to all zeros when no bit of `isr_in` is set.
- R8: While ready, a command word with bits 4:3 = 00 and any other combination of bits 7, 6 and 5 pulses `cmd_err` and leaves `isr_clr` at 0.
- R9: While ready, a command word with bits 4:3 = 01 is accepted. It causes no error, no in-service clear and no change of mask or state.
- R10: A command-port write with bit 4 = 0 while not ready (idle or mid-initialization) pulses `cmd_err` and leaves the sequencer state unchanged.
- R11: A write whose `wr_len` is not 1 is ignored. It pulses `cmd_err`, does not pulse `clr_pend`, and changes no mask, base or state.
- R12: Every write with `wr_len` = 1, erroneous or not, pulses `clr_pend` for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per access |
| wr_sel | input | 1 | Port select: 0 = command port, 1 = data port |
| wr_len | input | LEN_W | Access length in bytes |
| wr_data | input | 8 | Written byte |
| isr_in | input | 2**LVL_W | In-service vector from the priority logic |
| vec_base | output | 8 | Stored vector base word |
| irq_mask | output | 8 | Interrupt mask register |
| isr_clr | output | 2**LVL_W | One-cycle in-service clear request |
| clr_pend | output | 1 | One-cycle pulse that clears the CPU-side pending indication |
| cmd_err | output | 1 | One-cycle error pulse |
| seq_ready | output | 1 | Initialization complete |

## Verification
The bench builds the block with LVL_W=3, which gives eight lines, with LEN_W=3 and the arithmetic lowest-bit picker. That configuration is small enough to sweep completely. It covers all 256 in-service patterns for the lowest-bit clear, all eight levels for the specific clear, all eight end-of-interrupt flag combinations, and all four start-word flag combinations. Each start-word combination is run through its full initialization path, with out-of-place command writes made along the way. Lengths 0, 2 and 7 exercise rejection on both ports.

// File: rtl/icu_pkg.sv
package icu_pkg;
   localparam int unsigned WORD_W   = 8;
   // command-word bit positions
   localparam int unsigned B_INIT   = 4;
   localparam int unsigned B_FMT    = 3;
   localparam int unsigned B_EOI    = 5;
   localparam int unsigned B_SEL    = 6;
   localparam int unsigned B_ROT    = 7;
   localparam int unsigned B_SNGL   = 1;
   localparam int unsigned B_MODEW  = 0;

   typedef enum logic [2:0] {
      ST_IDLE, ST_BASE, ST_CASC, ST_MODE, ST_READY
   } seq_st_e;

   typedef enum logic [2:0] {
      ACT_NONE, ACT_INIT, ACT_DATA, ACT_CLR_SPEC, ACT_CLR_LOW, ACT_ERR
   } act_e;
endpackage

// File: rtl/icu_lowest_pick.sv
module icu_lowest_pick #(
   parameter int unsigned W     = 8,
   parameter bit          ARITH = 1'b1
) (
   input  logic [W-1:0] vec,
   output logic [W-1:0] pick
);
   if (ARITH) begin : g_arith
      assign pick = vec & (~vec + W'(1));
   end else begin : g_scan
      always_comb begin
         logic found;
         found = 1'b0;
         pick  = '0;
         for (int i = 0; i < int'(W); i++) begin
            if (vec[i] && !found) begin
               pick[i] = 1'b1;
               found   = 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/icu_cmd_decode.sv
module icu_cmd_decode
   import icu_pkg::*;
#(
   parameter int unsigned LEN_W = 3
) (
   input  logic             wr_en,
   input  logic             wr_sel,
   input  logic [LEN_W-1:0] wr_len,
   input  logic [7:3]       op_hi,
   input  seq_st_e          st,
   output act_e             act,
   output logic             accepted
);
   assign accepted = wr_en && (wr_len == LEN_W'(1));

   always_comb begin
      act = ACT_NONE;
      if (wr_en && !accepted) begin
         act = ACT_ERR;
      end else if (accepted && wr_sel) begin
         act = ACT_DATA;
      end else if (accepted) begin
         if (op_hi[B_INIT]) begin
            act = ACT_INIT;
         end else if (st != ST_READY) begin
            act = ACT_ERR;
         end else if (op_hi[B_FMT]) begin
            act = ACT_NONE;
         end else if (op_hi[B_EOI] && !op_hi[B_ROT]) begin
            act = op_hi[B_SEL] ? ACT_CLR_SPEC : ACT_CLR_LOW;
         end else begin
            act = ACT_ERR;
         end
      end
   end
endmodule

// File: rtl/icu_seq_fsm.sv
module icu_seq_fsm
   import icu_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  act_e              act,
   input  logic [WORD_W-1:0] wr_data,
   output seq_st_e           st,
   output logic [WORD_W-1:0] vec_base,
   output logic              mask_ld
);
   seq_st_e st_d;
   logic    sngl_q, modew_q;

   always_comb begin
      st_d    = st;
      mask_ld = 1'b0;
      case (act)
         ACT_INIT: st_d = ST_BASE;
         ACT_DATA: begin
            case (st)
               ST_BASE: st_d = !sngl_q ? ST_CASC : (modew_q ? ST_MODE : ST_READY);
               ST_CASC: st_d = modew_q ? ST_MODE : ST_READY;
               ST_MODE: st_d = ST_READY;
               default: mask_ld = 1'b1;
            endcase
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         sngl_q   <= 1'b0;
         modew_q  <= 1'b0;
         vec_base <= '0;
      end else begin
         st <= st_d;
         if (act == ACT_INIT) begin
            sngl_q  <= wr_data[B_SNGL];
            modew_q <= wr_data[B_MODEW];
         end
         if (act == ACT_DATA && st == ST_BASE) vec_base <= wr_data;
      end
   end
endmodule

// File: rtl/icu_cmd_seq.sv
module icu_cmd_seq
   import icu_pkg::*;
#(
   parameter int unsigned LVL_W        = 3,
   parameter int unsigned LEN_W        = 3,
   parameter bit          LOWEST_ARITH = 1'b1,
   parameter logic [7:0]  MASK_RST     = 8'hFF,
   localparam int unsigned NL          = 1 << LVL_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             wr_sel,
   input  logic [LEN_W-1:0] wr_len,
   input  logic [7:0]       wr_data,
   input  logic [NL-1:0]    isr_in,
   output logic [7:0]       vec_base,
   output logic [7:0]       irq_mask,
   output logic [NL-1:0]    isr_clr,
   output logic             clr_pend,
   output logic             cmd_err,
   output logic             seq_ready
);
   if (LVL_W < 1 || LVL_W > 3) begin : g_bad_lvl
      $error("LVL_W must lie in 1..3: the level field is bits 2:0");
   end
   if (LEN_W < 1) begin : g_bad_len
      $error("LEN_W must be at least 1");
   end

   seq_st_e         st;
   act_e            act;
   logic            accepted, mask_ld;
   logic [NL-1:0]   low_pick, clr_d;

   icu_cmd_decode #(.LEN_W(LEN_W)) u_dec (
      .wr_en    (wr_en),
      .wr_sel   (wr_sel),
      .wr_len   (wr_len),
      .op_hi    (wr_data[7:3]),
      .st       (st),
      .act      (act),
      .accepted (accepted)
   );

   icu_seq_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .act      (act),
      .wr_data  (wr_data),
      .st       (st),
      .vec_base (vec_base),
      .mask_ld  (mask_ld)
   );

   icu_lowest_pick #(.W(NL), .ARITH(LOWEST_ARITH)) u_pick (
      .vec  (isr_in),
      .pick (low_pick)
   );

   always_comb begin
      case (act)
         ACT_CLR_SPEC: clr_d = NL'(1) << wr_data[LVL_W-1:0];
         ACT_CLR_LOW:  clr_d = low_pick;
         default:      clr_d = '0;
      endcase
   end

   assign seq_ready = (st == ST_READY);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_mask <= MASK_RST;
         isr_clr  <= '0;
         clr_pend <= 1'b0;
         cmd_err  <= 1'b0;
      end else begin
         if (mask_ld) irq_mask <= wr_data;
         isr_clr  <= clr_d;
         clr_pend <= accepted;
         cmd_err  <= (act == ACT_ERR);
      end
   end
endmodule

// File: rtl/icu_cmd_seq_chk.sv
module icu_cmd_seq_chk #(
   parameter int unsigned LVL_W = 3,
   parameter int unsigned LEN_W = 3,
   localparam int unsigned NL   = 1 << LVL_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic             wr_sel,
   input logic [LEN_W-1:0] wr_len,
   input logic [7:0]       wr_data,
   input logic [7:0]       vec_base,
   input logic [7:0]       irq_mask,
   input logic [NL-1:0]    isr_clr,
   input logic             clr_pend,
   input logic             cmd_err,
   input logic             seq_ready
);
   // R12
   clr_pend_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_pend |-> $past(wr_en && wr_len == LEN_W'(1)));

   // R6
   isr_clr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(isr_clr));

   // R7
   isr_clr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|isr_clr) |-> $past(wr_en && !wr_sel && wr_len == LEN_W'(1) && seq_ready));

   // R5
   mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(irq_mask) |-> $past(wr_en && wr_sel && wr_len == LEN_W'(1)));

   // R3
   vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(vec_base) |-> $past(wr_en && wr_sel && wr_len == LEN_W'(1) && !seq_ready));

   // R4
   ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(seq_ready) |-> $past(wr_en && wr_sel));

   // R2
   ready_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(seq_ready) |-> $past(wr_en && !wr_sel && wr_data[4]));

   // R11
   len_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_err && !clr_pend) |-> $past(wr_en && wr_len != LEN_W'(1)));
endmodule

bind icu_cmd_seq icu_cmd_seq_chk #(.LVL_W(LVL_W), .LEN_W(LEN_W)) u_chk (.*);

// File: tb/tb_icu_cmd_seq.sv
`timescale 1ns/1ps
module tb_icu_cmd_seq;
   localparam int LVL_W = 3;
   localparam int LEN_W = 3;
   localparam int NL    = 1 << LVL_W;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             wr_en = 1'b0;
   logic             wr_sel = 1'b0;
   logic [LEN_W-1:0] wr_len = '0;
   logic [7:0]       wr_data = '0;
   logic [NL-1:0]    isr_in = '0;
   logic [7:0]       vec_base, irq_mask;
   logic [NL-1:0]    isr_clr;
   logic             clr_pend, cmd_err, seq_ready;

   int errors = 0;
   int checks = 0;

   always #2 clk = ~clk;

   icu_cmd_seq #(.LVL_W(LVL_W), .LEN_W(LEN_W), .LOWEST_ARITH(1'b1)) dut (.*);

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // one-cycle write; returns at the negedge after the capturing edge
   task automatic wr(input logic sel, input logic [LEN_W-1:0] len, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_len = len; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   function automatic logic [NL-1:0] lowest(input logic [NL-1:0] v);
      for (int i = 0; i < NL; i++) if (v[i]) return NL'(1) << i;
      return '0;
   endfunction

   initial begin
      #(4 * 150000);
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [7:0] m;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 ready", seq_ready, 0);
      chk("R1 base", vec_base, 0);
      chk("R1 mask", irq_mask, 8'hFF);
      chk("R1 pulses", {isr_clr, clr_pend, cmd_err}, 0);
      rst_n = 1'b1;

      // R10 command word in idle
      wr(1'b0, 1, 8'h20);
      chk("R10 err idle", cmd_err, 1);
      chk("R12 pend on err", clr_pend, 1);
      chk("R10 still idle", seq_ready, 0);
      @(negedge clk);
      chk("R12 single pulse", clr_pend, 0);
      // R5 mask in idle
      wr(1'b1, 1, 8'h5A);
      chk("R5 idle mask", irq_mask, 8'h5A);

      for (int c = 0; c < 4; c++) begin
         int extra;
         m = irq_mask;
         extra = (c[1] ? 0 : 1) + (c[0] ? 1 : 0);
         wr(1'b0, 1, 8'h10 | 8'(c));
         chk("R2 start drops ready", seq_ready, 0);
         chk("R12 pend init", clr_pend, 1);
         wr(1'b1, 1, 8'h20 + 8'(8 * c));
         chk("R3 base", vec_base, 8'h20 + 8'(8 * c));
         for (int k = 0; k < extra; k++) begin
            chk("R3 R4 not yet ready", seq_ready, 0);
            wr(1'b0, 1, 8'h20);
            chk("R10 err mid-init", cmd_err, 1);
            chk("R10 no clear mid-init", isr_clr, 0);
            wr(1'b1, 1, 8'h00);
         end
         chk("R4 ready after script", seq_ready, 1);
         chk("R3 mask untouched", irq_mask, m);
         chk("R3 base kept", vec_base, 8'h20 + 8'(8 * c));
         wr(1'b1, 1, 8'h3C + 8'(c));
         chk("R5 ready mask", irq_mask, 8'h3C + 8'(c));
      end

      // R6 specific clear, all levels
      for (int l = 0; l < NL; l++) begin
         isr_in = 8'hFF;
         wr(1'b0, 1, 8'h60 | 8'(l));
         chk("R6 specific", isr_clr, NL'(1) << l);
         chk("R6 no err", cmd_err, 0);
         @(negedge clk);
         chk("R6 one cycle", isr_clr, 0);
      end

      // R7 lowest-set clear, all in-service patterns
      for (int v = 0; v < 256; v++) begin
         isr_in = NL'(v);
         wr(1'b0, 1, 8'h25);
         chk("R7 lowest", isr_clr, lowest(NL'(v)));
      end

      // R8 other flag combinations
      for (int f = 0; f < 8; f++) begin
         logic [2:0] fl;
         fl = 3'(f); // {R, SL, EOI}
         isr_in = 8'hFF;
         if (!(fl[0] && !fl[2])) begin
            wr(1'b0, 1, {fl[2], fl[1], fl[0], 5'b00011});
            chk("R8 err", cmd_err, 1);
            chk("R8 no clear", isr_clr, 0);
            chk("R8 still ready", seq_ready, 1);
         end
      end

      // R9 third format word
      m = irq_mask;
      wr(1'b0, 1, 8'h08);
      chk("R9 no err", cmd_err, 0);
      chk("R9 no clear", isr_clr, 0);
      wr(1'b0, 1, 8'hEB);
      chk("R9 no err b", cmd_err, 0);
      chk("R9 ready kept", seq_ready, 1);
      chk("R9 mask kept", irq_mask, m);

      // R11 bad lengths
      for (int q = 0; q < 3; q++) begin
         logic [LEN_W-1:0] ln;
         ln = (q == 0) ? 3'd0 : (q == 1) ? 3'd2 : 3'd7;
         wr(1'b1, ln, 8'h00);
         chk("R11 err", cmd_err, 1);
         chk("R11 no pend", clr_pend, 0);
         chk("R11 mask kept", irq_mask, m);
         wr(1'b0, ln, 8'h11);
         chk("R11 start ignored", seq_ready, 1);
         chk("R11 no pend cmd", clr_pend, 0);
      end

      // R2 restart from ready, single bank without mode word
      wr(1'b0, 1, 8'h12);
      chk("R2 restart", seq_ready, 0);
      wr(1'b1, 1, 8'hA8);
      chk("R3 direct ready", seq_ready, 1);
      chk("R3 base again", vec_base, 8'hA8);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule